// File: doc/BRIEF.md
# Programmable Reload Frequency Divider

This block divides its clock by a programmable ratio of one to sixteen. A small four-bit counter steps in a fixed direction. When it reaches its end value, its own end-of-count flag switches it into load mode, and the program value goes back in at the next rising edge. No other gating is used. The period is therefore the program value plus one clock cycles. The divided output is a pulse one clock wide, high in the cycle where the reload is selected.

The counting direction is chosen at build time. When counting down, the counter loads the program value and runs to zero. When counting up, it loads the bitwise complement of the program value and runs to all ones. Both give the same ratio for the same program input. The program input is sampled only at reload edges, so a new value takes effect from the next period and never cuts one short.

Top module: `prog_div_top`

## Requirements
- R1: With COUNT_UP = 0 and program value N, pulse_o rises once every N+1 clock cycles.
- R2: With COUNT_UP = 1 and program value N, pulse_o rises once every N+1 clock cycles.
- R3: For N from 1 to 15, pulse_o is high for exactly one cycle and low in the cycle after.
- R4: With N = 0, pulse_o stays high on every cycle, which divides by one.
- R5: The program value is taken only on the rising edge that ends a pulse cycle. A change at any other time leaves the current period unchanged, and a change made in the pulse cycle itself is loaded at that edge.
- R6: While rst_ni is low, count_o holds its end value (0 counting down, 15 counting up) and pulse_o is high. The first rising edge after release loads the program value.
- R7: After a reload, count_o walks N, N-1, ..., 0 when counting down. When counting up, it walks (15-N), ..., 15, because the loaded value is the bitwise complement of N. Between reloads it moves by exactly one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_i | input | WIDTH (4) | Program value N; ratio is N+1 |
| pulse_o | output | 1 | Divided output, one cycle high per period |
| count_o | output | WIDTH (4) | Present counter state |

## Verification
Two events can share a cycle: the end-of-count reload, and a change of the program input. The bench changes the program value in the middle of a period and checks that the old ratio completes first. It then changes the value again in the exact cycle where pulse_o is high, and checks that the new value is the one loaded at that edge. Expected counts and pulse positions come from modular arithmetic on the cycle number since reset release. Both directions are swept over all sixteen program values.

// File: rtl/prog_div_pkg.sv
package prog_div_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_UP   = 2'd1,
    OP_DOWN = 2'd2,
    OP_HOLD = 2'd3
  } ctr_op_e;
endpackage

// File: rtl/prog_div_core.sv
module prog_div_core
  import prog_div_pkg::*;
#(
  parameter int unsigned WIDTH    = 4,
  parameter bit          COUNT_UP = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctr_op_e          op_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_o
);
  localparam logic [WIDTH-1:0] END_VAL = COUNT_UP ? {WIDTH{1'b1}} : '0;

  logic [WIDTH-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= END_VAL;
    else begin
      unique case (op_i)
        OP_LOAD: q <= load_val_i;
        OP_UP:   q <= q + 1'b1;
        OP_DOWN: q <= q - 1'b1;
        default: q <= q;
      endcase
    end
  end

  // end-of-count from state only; op depends on it
  assign tc_o    = (q == END_VAL);
  assign count_o = q;

  // R5
  load_takes_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_LOAD |=> q == $past(load_val_i));

  // R7
  step_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_DOWN |=> q == $past(q) - 1'b1);

  // R7
  step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_UP |=> q == $past(q) + 1'b1);
endmodule

// File: rtl/prog_div_ctrl.sv
module prog_div_ctrl
  import prog_div_pkg::*;
#(
  parameter int unsigned WIDTH    = 4,
  parameter bit          COUNT_UP = 1'b0
) (
  input  logic             tc_i,
  input  logic [WIDTH-1:0] prog_i,
  output ctr_op_e          op_o,
  output logic [WIDTH-1:0] load_val_o
);
  generate
    if (COUNT_UP) begin : g_up
      assign load_val_o = ~prog_i;
      assign op_o       = tc_i ? OP_LOAD : OP_UP;
    end else begin : g_down
      assign load_val_o = prog_i;
      assign op_o       = tc_i ? OP_LOAD : OP_DOWN;
    end
  endgenerate
endmodule

// File: rtl/prog_div_top.sv
module prog_div_top
  import prog_div_pkg::*;
#(
  parameter int unsigned WIDTH    = 4,
  parameter bit          COUNT_UP = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] prog_i,
  output logic             pulse_o,
  output logic [WIDTH-1:0] count_o
);
  ctr_op_e          op;
  logic [WIDTH-1:0] load_val;
  logic             tc;

  prog_div_ctrl #(.WIDTH(WIDTH), .COUNT_UP(COUNT_UP)) u_ctrl (
    .tc_i       (tc),
    .prog_i     (prog_i),
    .op_o       (op),
    .load_val_o (load_val)
  );

  prog_div_core #(.WIDTH(WIDTH), .COUNT_UP(COUNT_UP)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .load_val_i (load_val),
    .count_o    (count_o),
    .tc_o       (tc)
  );

  assign pulse_o = tc;

  // R3
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o && (prog_i != '0) |=> !pulse_o);

  // R4
  div_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o && (prog_i == '0) |=> pulse_o);

  // R5
  reload_from_prog_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> count_o == (COUNT_UP ? ~$past(prog_i) : $past(prog_i)));
endmodule

// File: tb/prog_div_top_test.sv
module prog_div_top_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] prog = 4'd0;
  logic       pulse_dn, pulse_up;
  logic [3:0] cnt_dn, cnt_up;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_div_top #(.WIDTH(4), .COUNT_UP(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .prog_i(prog), .pulse_o(pulse_dn), .count_o(cnt_dn));

  prog_div_top #(.WIDTH(4), .COUNT_UP(1'b1)) uut_up (
    .clk_i(clk), .rst_ni(rst_ni), .prog_i(prog), .pulse_o(pulse_up), .count_o(cnt_up));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs(input int exp_dn, input int exp_up, input bit exp_p,
                               input string ptag_dn, input string ptag_up);
    chk(cnt_dn == exp_dn[3:0], "R7 down count", cnt_dn, exp_dn);
    chk(cnt_up == exp_up[3:0], "R7 up count", cnt_up, exp_up);
    chk(pulse_dn == exp_p, ptag_dn, pulse_dn, exp_p);
    chk(pulse_up == exp_p, ptag_up, pulse_up, exp_p);
  endtask

  task automatic do_reset(input logic [3:0] n);
    rst_ni = 1'b0;
    prog   = n;
    @(negedge clk);
    @(negedge clk);
    // R6: end value and pulse high during reset
    check_outputs(0, 15, 1'b1, "R6 down pulse", "R6 up pulse");
    rst_ni = 1'b1;
  endtask

  task automatic sweep(input int n);
    string tdn, tup;
    do_reset(n[3:0]);
    check_outputs(0, 15, 1'b1, "R6 down pulse", "R6 up pulse");
    for (int k = 1; k <= 3 * (n + 1) + 1; k++) begin
      bit p;
      @(negedge clk);
      p = ((k % (n + 1)) == 0);
      if (n == 0) begin tdn = "R4 down pulse"; tup = "R4 up pulse"; end
      else if (p) begin tdn = "R1 down pulse"; tup = "R2 up pulse"; end
      else begin tdn = "R3 down pulse"; tup = "R3 up pulse"; end
      check_outputs(n - ((k - 1) % (n + 1)), (15 - n) + ((k - 1) % (n + 1)), p, tdn, tup);
    end
  endtask

  task automatic change_test();
    do_reset(4'd5);
    check_outputs(0, 15, 1'b1, "R6 down pulse", "R6 up pulse");
    for (int k = 1; k <= 14; k++) begin
      int ed, eu;
      bit p;
      @(negedge clk);
      if (k <= 6) begin
        ed = 5 - (k - 1); eu = 10 + (k - 1); p = (k == 6);
      end else if (k <= 9) begin
        ed = 2 - (k - 7); eu = 13 + (k - 7); p = (k == 9);
      end else begin
        ed = 0; eu = 15; p = 1'b1;
      end
      check_outputs(ed, eu, p, "R5 down pulse", "R5 up pulse");
      if (k == 3) prog = 4'd2;       // mid-period change
      if (k == 9) prog = 4'd0;       // change in the pulse cycle
    end
  endtask

  initial begin
    for (int n = 0; n < 16; n++) sweep(n);
    change_test();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule